// File: doc/BRIEF.md
# Decoded Packet Byte Framer

This block sits on the receive path after the error-correction decoder. It takes the decoded byte stream, in which a start marker flags the first byte of each packet and a status bit tells whether the decoder could repair that packet. It puts each packet back on a byte bus with three flags: sync, payload and packet-OK. A packet is one sync byte, then the payload bytes, then sixteen parity bytes. Two packet sizes exist: a 255-byte packet with 238 payload bytes in internal-sync mode, and a 240-byte packet with 223 payload bytes in external-sync mode.

Both data interfaces are valid/ready. The output valid signal is the gated byte clock enable: it is high only while a byte (sync, payload or parity) is on the bus, and a byte moves when `out_valid` and `out_ready` are both high. While a byte waits for `out_ready`, the bus and all flags stay unchanged. `in_ready` is high when the single output slot is empty or is being emptied in that cycle, and the framer is not producing parity filler itself. When coding is disabled, the upstream stream carries only the sync and payload bytes, and the framer appends the sixteen parity positions from its own filler value.

Top module: `rsof_framer`

## Requirements
- R1: After reset, `out_valid` is low and stays low until a start-marked input byte is accepted.
- R2: An input byte accepted without `in_sop` while no packet is open is consumed and produces no output; a packet only begins with a start-marked byte.
- R3: The first output byte of a packet carries `out_sync`=1 and `out_payload`=0; every other byte carries `out_sync`=0.
- R4: With `cfg_ext_sync`=0 at the start byte, byte positions 1 to 238 carry `out_payload`=1 and positions 239 to 254 carry `out_payload`=0, 255 bytes in total.
- R5: With `cfg_ext_sync`=1 at the start byte, byte positions 1 to 223 carry `out_payload`=1 and positions 224 to 239 carry `out_payload`=0, 240 bytes in total.
- R6: `cfg_ext_sync` and `cfg_rs_bypass` are sampled only with the start byte; changing them inside a packet alters nothing until the next start byte.
- R7: `out_pkt_ok` equals the `in_pkt_ok` value given with the start byte, on every byte of that packet, whatever `in_pkt_ok` does later.
- R8: With `cfg_rs_bypass`=1 at the start byte, the input supplies only sync and payload bytes; after the last payload byte the framer emits 16 parity bytes of value 0x00, and `in_ready` stays low while it does so.
- R9: While `out_valid`=1 and `out_ready`=0, `out_valid`, `out_data` and all three flags hold their values in the next cycle.
- R10: A start-marked byte accepted inside a packet ends that packet at once and begins a new one as its sync byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Framer takes the input byte this cycle |
| in_data | input | 8 | Decoded byte |
| in_sop | input | 1 | Marks the sync byte of a packet |
| in_pkt_ok | input | 1 | Decoder verdict for the packet, read with the start byte |
| cfg_ext_sync | input | 1 | 0: 255/238 packet, 1: 240/223 packet |
| cfg_rs_bypass | input | 1 | 1: input omits parity, framer inserts filler |
| out_valid | output | 1 | Byte on bus; gated byte clock enable |
| out_ready | input | 1 | Downstream takes the byte |
| out_data | output | 8 | Output byte |
| out_sync | output | 1 | Sync byte on bus |
| out_payload | output | 1 | Payload byte on bus |
| out_pkt_ok | output | 1 | Current packet is error-free or corrected |

## Verification
A position counter that is off by one shows within a single packet: the payload flag then drops one byte early or late, at position 238 or 223, or the packet ends at the wrong length, so the next sync byte is misplaced. A mode or status latch that follows its input instead of holding it shows on the first byte after a mid-packet change of the configuration or the OK input. A filler state that lets input through shows when the next start byte, presented at once, cuts off the parity run. A slot flag that overwrites a waiting byte shows in the first stalled cycle, as a changed bus or a lost byte.

// File: rtl/rsof_pkg.sv
package rsof_pkg;

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_PASS = 2'd1,
    ST_FILL = 2'd2
  } rsof_state_e;

  typedef struct packed {
    logic sync;
    logic payload;
    logic pkt_ok;
  } rsof_flags_t;

  function automatic int unsigned rsof_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rsof_classify.sv
module rsof_classify #(
  parameter int unsigned POS_W     = 8,
  parameter int unsigned PAR_BYTES = 16
) (
  input  logic [POS_W-1:0] pos,
  input  logic [POS_W-1:0] pay_len,
  output logic             is_payload,
  output logic             at_last_pay,
  output logic             at_last
);

  logic [POS_W-1:0] last_idx;

  assign last_idx    = pay_len + POS_W'(PAR_BYTES);
  assign is_payload  = (pos != '0) && (pos <= pay_len);
  assign at_last_pay = (pos == pay_len);
  assign at_last     = (pos == last_idx);

endmodule

// File: rtl/rsof_ctrl.sv
module rsof_ctrl
  import rsof_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned PAY_INT   = 238,
  parameter int unsigned PAY_EXT   = 223,
  parameter int unsigned PAR_BYTES = 16,
  parameter logic [DATA_W-1:0] FILL_BYTE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sop,
  input  logic              in_pkt_ok,
  input  logic              cfg_ext_sync,
  input  logic              cfg_rs_bypass,
  input  logic              slot_free,
  output logic              emit,
  output logic [DATA_W-1:0] emit_data,
  output rsof_flags_t       emit_flags
);

  localparam int unsigned PAY_MAX = rsof_max(PAY_INT, PAY_EXT);
  localparam int unsigned POS_W   = $clog2(PAY_MAX + PAR_BYTES + 1);

  rsof_state_e      state_q, state_d;
  logic [POS_W-1:0] pos_q, pos_d;
  logic [POS_W-1:0] pay_len_q, pay_len_d;
  logic             bypass_q, bypass_d;
  logic             ok_q, ok_d;
  logic             take, start;
  logic             is_payload, at_last_pay, at_last;

  rsof_classify #(
    .POS_W    (POS_W),
    .PAR_BYTES(PAR_BYTES)
  ) classify_i (
    .pos        (pos_q),
    .pay_len    (pay_len_q),
    .is_payload (is_payload),
    .at_last_pay(at_last_pay),
    .at_last    (at_last)
  );

  always_comb begin
    state_d    = state_q;
    pos_d      = pos_q;
    pay_len_d  = pay_len_q;
    bypass_d   = bypass_q;
    ok_d       = ok_q;
    emit       = 1'b0;
    emit_data  = in_data;
    emit_flags = '0;
    in_ready   = slot_free && (state_q != ST_FILL);
    take       = in_valid && in_ready;
    start      = take && in_sop;

    if (start) begin
      emit       = 1'b1;
      emit_flags = '{sync: 1'b1, payload: 1'b0, pkt_ok: in_pkt_ok};
      pos_d      = POS_W'(1);
      pay_len_d  = cfg_ext_sync ? POS_W'(PAY_EXT) : POS_W'(PAY_INT);
      bypass_d   = cfg_rs_bypass;
      ok_d       = in_pkt_ok;
      state_d    = ST_PASS;
    end else begin
      case (state_q)
        ST_PASS: begin
          if (take) begin
            emit       = 1'b1;
            emit_flags = '{sync: 1'b0, payload: is_payload, pkt_ok: ok_q};
            pos_d      = pos_q + POS_W'(1);
            if (at_last) begin
              state_d = ST_HUNT;
            end else if (bypass_q && at_last_pay) begin
              state_d = ST_FILL;
            end
          end
        end
        ST_FILL: begin
          if (slot_free) begin
            emit       = 1'b1;
            emit_data  = FILL_BYTE;
            emit_flags = '{sync: 1'b0, payload: 1'b0, pkt_ok: ok_q};
            pos_d      = pos_q + POS_W'(1);
            if (at_last) begin
              state_d = ST_HUNT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_HUNT;
      pos_q     <= '0;
      pay_len_q <= POS_W'(PAY_INT);
      bypass_q  <= 1'b0;
      ok_q      <= 1'b0;
    end else begin
      state_q   <= state_d;
      pos_q     <= pos_d;
      pay_len_q <= pay_len_d;
      bypass_q  <= bypass_d;
      ok_q      <= ok_d;
    end
  end

endmodule

// File: rtl/rsof_outreg.sv
module rsof_outreg
  import rsof_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              emit,
  input  logic [DATA_W-1:0] emit_data,
  input  rsof_flags_t       emit_flags,
  input  logic              out_ready,
  output logic              slot_free,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output rsof_flags_t       out_flags
);

  assign slot_free = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_flags <= '0;
    end else if (emit) begin
      out_valid <= 1'b1;
      out_data  <= emit_data;
      out_flags <= emit_flags;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/rsof_framer.sv
module rsof_framer
  import rsof_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned PAY_INT   = 238,
  parameter int unsigned PAY_EXT   = 223,
  parameter int unsigned PAR_BYTES = 16,
  parameter logic [DATA_W-1:0] FILL_BYTE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sop,
  input  logic              in_pkt_ok,
  input  logic              cfg_ext_sync,
  input  logic              cfg_rs_bypass,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sync,
  output logic              out_payload,
  output logic              out_pkt_ok
);

  logic              slot_free;
  logic              emit;
  logic [DATA_W-1:0] emit_data;
  rsof_flags_t       emit_flags;
  rsof_flags_t       out_flags;

  rsof_ctrl #(
    .DATA_W   (DATA_W),
    .PAY_INT  (PAY_INT),
    .PAY_EXT  (PAY_EXT),
    .PAR_BYTES(PAR_BYTES),
    .FILL_BYTE(FILL_BYTE)
  ) ctrl_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_data      (in_data),
    .in_sop       (in_sop),
    .in_pkt_ok    (in_pkt_ok),
    .cfg_ext_sync (cfg_ext_sync),
    .cfg_rs_bypass(cfg_rs_bypass),
    .slot_free    (slot_free),
    .emit         (emit),
    .emit_data    (emit_data),
    .emit_flags   (emit_flags)
  );

  rsof_outreg #(
    .DATA_W(DATA_W)
  ) outreg_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .emit      (emit),
    .emit_data (emit_data),
    .emit_flags(emit_flags),
    .out_ready (out_ready),
    .slot_free (slot_free),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_flags (out_flags)
  );

  assign out_sync    = out_flags.sync;
  assign out_payload = out_flags.payload;
  assign out_pkt_ok  = out_flags.pkt_ok;

endmodule

// File: rtl/rsof_checker.sv
module rsof_checker
  import rsof_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned PAY_INT   = 238,
  parameter int unsigned PAY_EXT   = 223,
  parameter int unsigned PAR_BYTES = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_sync,
  input logic              out_payload,
  input logic              out_pkt_ok
);

  localparam int unsigned PAY_MAX = rsof_max(PAY_INT, PAY_EXT);
  localparam int unsigned MAX_LEN = PAY_MAX + PAR_BYTES + 1;
  localparam int unsigned CNT_W   = $clog2(MAX_LEN + 2);

  logic             acc;
  logic [CNT_W-1:0] cnt;
  logic             in_pkt;
  logic             ok_seen;

  assign acc = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      in_pkt  <= 1'b0;
      ok_seen <= 1'b0;
    end else if (acc) begin
      if (out_sync) begin
        cnt     <= CNT_W'(1);
        in_pkt  <= 1'b1;
        ok_seen <= out_pkt_ok;
      end else if (cnt < CNT_W'(MAX_LEN)) begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  // R2: the first byte ever delivered is a sync byte
  p_first_is_sync_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !in_pkt |-> out_sync);

  // R3: sync and payload are never flagged together
  p_sync_excl_payload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_sync && out_payload));

  // R4: no packet runs past the longest length
  p_len_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !out_sync && in_pkt |-> cnt < CNT_W'(MAX_LEN));

  // R5: payload flag only inside the payload window
  p_payload_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc && out_payload |-> in_pkt && (cnt >= CNT_W'(1)) && (cnt <= CNT_W'(PAY_MAX)));

  // R7: packet status constant over the packet
  p_ok_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !out_sync && in_pkt |-> out_pkt_ok == ok_seen);

  // R9: a waiting byte holds bus and flags
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sync)
      && $stable(out_payload) && $stable(out_pkt_ok));

endmodule

bind rsof_framer rsof_checker #(
  .DATA_W   (DATA_W),
  .PAY_INT  (PAY_INT),
  .PAY_EXT  (PAY_EXT),
  .PAR_BYTES(PAR_BYTES)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .out_sync   (out_sync),
  .out_payload(out_payload),
  .out_pkt_ok (out_pkt_ok)
);

// File: tb/rsof_framer_tb_top.sv
`timescale 1ns/1ps
module rsof_framer_tb_top;

  typedef struct {
    logic [7:0] d;
    logic       s;
    logic       p;
    logic       ok;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic       in_sop = 1'b0;
  logic       in_pkt_ok = 1'b0;
  logic       cfg_ext_sync = 1'b0;
  logic       cfg_rs_bypass = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_data;
  logic       out_sync;
  logic       out_payload;
  logic       out_pkt_ok;

  int   n_checks = 0;
  int   n_fail   = 0;
  bit   done     = 1'b0;
  bit   rdy_rand = 1'b0;
  logic [15:0] lfsr_in  = 16'hACE1;
  logic [15:0] lfsr_out = 16'h5A3C;
  exp_t q[$];

  always #2.5 clk = ~clk;

  rsof_framer dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_data      (in_data),
    .in_sop       (in_sop),
    .in_pkt_ok    (in_pkt_ok),
    .cfg_ext_sync (cfg_ext_sync),
    .cfg_rs_bypass(cfg_rs_bypass),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_data     (out_data),
    .out_sync     (out_sync),
    .out_payload  (out_payload),
    .out_pkt_ok   (out_pkt_ok)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  function automatic logic step_in();
    lfsr_in = {lfsr_in[14:0], lfsr_in[15] ^ lfsr_in[13] ^ lfsr_in[12] ^ lfsr_in[10]};
    return lfsr_in[0] & lfsr_in[5];
  endfunction

  // output back-pressure pattern
  initial begin
    forever begin
      @(posedge clk);
      #1;
      lfsr_out = {lfsr_out[14:0], lfsr_out[15] ^ lfsr_out[13] ^ lfsr_out[12] ^ lfsr_out[10]};
      out_ready = rdy_rand ? (lfsr_out[0] | lfsr_out[3]) : 1'b1;
    end
  end

  // monitor: scoreboard compare and stall-hold check
  logic       prev_stall = 1'b0;
  logic [7:0] held_d;
  logic [2:0] held_f;
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (prev_stall) begin
          n_checks++;
          if (!out_valid || out_data !== held_d ||
              {out_sync, out_payload, out_pkt_ok} !== held_f) begin
            n_fail++;
            $display("FAIL R9 stalled byte changed: got v=%0b d=%02h f=%03b exp d=%02h f=%03b",
                     out_valid, out_data, {out_sync, out_payload, out_pkt_ok}, held_d, held_f);
          end
        end
        prev_stall = out_valid && !out_ready;
        held_d = out_data;
        held_f = {out_sync, out_payload, out_pkt_ok};
        if (out_valid && out_ready) begin
          n_checks++;
          if (q.size() == 0) begin
            n_fail++;
            $display("FAIL R2 unexpected output byte: got d=%02h sync=%0b exp none",
                     out_data, out_sync);
          end else begin
            exp_t e;
            e = q.pop_front();
            if (out_data !== e.d || out_sync !== e.s || out_payload !== e.p) begin
              n_fail++;
              $display("FAIL %s byte: got d=%02h sync=%0b pay=%0b exp d=%02h sync=%0b pay=%0b",
                       e.tag, out_data, out_sync, out_payload, e.d, e.s, e.p);
            end else if (out_pkt_ok !== e.ok) begin
              n_fail++;
              $display("FAIL R7 packet ok: got %0b exp %0b", out_pkt_ok, e.ok);
            end
          end
        end
      end
    end
  end

  task automatic drive_byte(input logic [7:0] d, input logic sop, input logic okin,
                            input bit push, input exp_t e, input int nfill);
    in_valid  = 1'b1;
    in_data   = d;
    in_sop    = sop;
    in_pkt_ok = okin;
    do @(negedge clk); while (!in_ready);
    if (push) begin
      q.push_back(e);
      for (int k = 0; k < nfill; k++) begin
        exp_t f;
        f.d = 8'h00; f.s = 1'b0; f.p = 1'b0; f.ok = e.ok; f.tag = "R8";
        q.push_back(f);
      end
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    in_sop   = 1'b0;
  endtask

  // nsend 0 means a complete packet; flip_at flips both config inputs mid-packet
  task automatic send_pkt(input bit ext, input bit byp, input bit ok, input int nsend,
                          input int flip_at, input bit gaps, input logic [7:0] seed,
                          input string tag_ovr);
    int pay, full, n;
    pay  = ext ? 223 : 238;
    full = byp ? pay + 1 : pay + 17;
    n    = (nsend == 0) ? full : nsend;
    cfg_ext_sync  = ext;
    cfg_rs_bypass = byp;
    for (int i = 0; i < n; i++) begin
      exp_t e;
      if (i == flip_at) begin
        cfg_ext_sync  = ~cfg_ext_sync;
        cfg_rs_bypass = ~cfg_rs_bypass;
      end
      e.d  = seed + 8'(i * 7);
      e.s  = (i == 0);
      e.p  = (i >= 1) && (i <= pay);
      e.ok = ok;
      if (tag_ovr != "")      e.tag = tag_ovr;
      else if (i == 0)        e.tag = "R3";
      else if (flip_at >= 0)  e.tag = "R6";
      else if (ext)           e.tag = "R5";
      else                    e.tag = "R4";
      // non-start bytes carry the inverted status to show it is ignored (R7)
      drive_byte(e.d, (i == 0), (i == 0) ? ok : ~ok, 1'b1, e,
                 (byp && nsend == 0 && i == pay) ? 16 : 0);
      if (gaps && step_in()) begin
        @(posedge clk);
        #1;
      end
    end
  endtask

  task automatic send_stray(input int n);
    exp_t e;
    e.d = 0; e.s = 0; e.p = 0; e.ok = 0; e.tag = "R2";
    for (int i = 0; i < n; i++) drive_byte(8'hE0 + 8'(i), 1'b0, 1'b1, 1'b0, e, 0);
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired: got running exp finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    n_checks++;
    if (out_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset out_valid: got %0b exp 0", out_valid);
    end
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    n_checks++;
    if (out_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 idle out_valid: got %0b exp 0", out_valid);
    end
    @(posedge clk);
    #1;

    send_stray(3);                                      // R2
    send_pkt(0, 0, 1, 0, -1, 0, 8'h10, "");             // R4
    send_pkt(1, 0, 0, 0, -1, 0, 8'h20, "");             // R5
    rdy_rand = 1'b1;                                    // R9
    send_pkt(0, 0, 0, 0, -1, 1, 8'h30, "");
    send_pkt(1, 0, 1, 0, -1, 1, 8'h40, "");
    send_pkt(0, 1, 1, 0, -1, 1, 8'h50, "");             // R8
    send_pkt(1, 1, 0, 0, -1, 0, 8'h60, "");             // R8
    send_pkt(0, 0, 1, 0, 10, 1, 8'h70, "");             // R6
    send_pkt(1, 1, 1, 0, 5, 0, 8'h80, "");              // R6
    send_pkt(0, 0, 0, 100, -1, 1, 8'h90, "R10");        // R10 truncated
    send_pkt(1, 0, 1, 0, -1, 0, 8'hA0, "");
    send_stray(2);                                      // R2
    send_pkt(0, 0, 1, 0, -1, 1, 8'hB0, "");

    for (int w = 0; w < 3000 && q.size() != 0; w++) @(posedge clk);
    repeat (20) @(posedge clk);
    @(negedge clk);
    n_checks++;
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL R4 bytes missing at end: got %0d pending exp 0", q.size());
    end
    done = 1'b1;
    summary();
    $finish;
  end

endmodule